// File: doc/BRIEF.md
# Bus Mastership Request Controller

This block decides when a device that shares an external bus with other masters may take that bus, keep it, or give it up. On the device side it receives a level request for an external access (`acc_req`) and a pulse that marks the end of a transfer sequence (`seq_end`). On the bus side it exchanges four active-low handshake signals with an outside arbiter and with the other masters. It drives a request out, samples a grant in, samples bus busy in, and drives bus busy and an acknowledge out.

Internally the block walks through four states: idle, parked (the arbiter grants the bus with no access wanted), pending (the request is out and the block waits for the bus) and master. Once a request is raised it stays raised until the access has been carried out. A copy of grant delayed by one clock lets a request that coincides with the removal of grant still be served. All outputs come from flops. The block has an asynchronous active-low reset whose release is synchronised to the clock.

Top module: `busmstr_ctrl`

## Requirements
- R1: While reset is active, and on the first cycles after its release, `br_n`, `ba_n` and `bb_n_out` are all 1.
- R2: In idle or parked, if `acc_req` is 1 and the bus cannot be taken at once (grant `bg_n`=1, or `bb_n_in`=0), the block enters pending. After that edge `{br_n,ba_n,bb_n_out}` = 3'b011.
- R3: In pending, `br_n` stays 0 whatever `acc_req` and `seq_end` do, until the bus has been taken.
- R4: From pending the block becomes master only on an edge where `bg_n`=0 and `bb_n_in`=1. After that edge the outputs are 3'b100. While `bb_n_in`=0 it stays pending, and `ba_n` is never asserted.
- R5: In idle, `acc_req`=1 together with `bg_n`=0 and `bb_n_in`=1 makes the block master on the next edge (outputs 3'b100). `br_n` is never asserted on the way.
- R6: In idle, `bg_n`=0 with `acc_req`=0 enters parked. Parked holds while grant stays, and all three outputs are 1.
- R7: In parked, `acc_req`=1 with grant held and the bus free goes straight to master without asserting `br_n`. Loss of grant with no request returns to idle.
- R8: As master, the block stays master (outputs 3'b100) while `seq_end`=0, whatever the grant does.
- R9: As master, `seq_end`=1 together with `acc_req`=1 keeps the block master when the one-clock-delayed grant is active. This also holds on the edge where `bg_n` rises.
- R10: As master, `seq_end`=1 otherwise releases `ba_n` and `bb_n_out` after that edge. The block then goes to pending if `acc_req`=1, to parked if grant is still held, and to idle otherwise.
- R11: In idle, with `acc_req`=0 and `bg_n`=1, the block stays idle with all outputs 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| acc_req | input | 1 | Device wants an external access (level) |
| seq_end | input | 1 | Current transfer sequence ends this cycle |
| bg_n | input | 1 | Bus grant from the arbiter, active low |
| bb_n_in | input | 1 | Bus busy as seen on the bus, active low |
| br_n | output | 1 | Bus request to the arbiter, active low |
| ba_n | output | 1 | Bus acknowledge, active low: the device owns the bus |
| bb_n_out | output | 1 | Bus busy driven by this device, active low |

## Verification
Two things can happen in the same clock: the end of a sequence and the removal of grant, with a fresh request arriving at that moment. The bench provokes this by raising `seq_end` and `acc_req` on the same edge where `bg_n` goes high. It expects the block to stay master, because the delayed grant is still active. One edge later, with both grant copies gone, it expects the move to pending. A second coincidence is a request that arrives on the edge where grant is present but the bus is still busy. The bench applies it from idle and requires pending, not master, and no acknowledge until busy clears.

// File: rtl/bm_pkg.sv
package bm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PARK = 2'd1,
    ST_PEND = 2'd2,
    ST_MAST = 2'd3
  } bm_state_e;

endpackage

// File: rtl/bm_rst_sync.sv
module bm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  localparam int MSB = STAGES - 1;

  logic [MSB:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[MSB-1:0], 1'b1};
    end
  end

  assign rst_ns = chain_q[MSB];
endmodule

// File: rtl/bm_gnt_dly.sv
module bm_gnt_dly #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst_ns,
  input  logic gnt,
  output logic gnt_dly
);
  localparam int MSB = DEPTH - 1;

  logic [MSB:0] pipe_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_ns) begin
        if (!rst_ns) pipe_q <= 1'b0;
        else         pipe_q <= gnt;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_ns) begin
        if (!rst_ns) pipe_q <= '0;
        else         pipe_q <= {pipe_q[MSB-1:0], gnt};
      end
    end
  endgenerate

  assign gnt_dly = pipe_q[MSB];
endmodule

// File: rtl/bm_fsm.sv
module bm_fsm
  import bm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_ns,
  input  logic      acc_req,
  input  logic      seq_end,
  input  logic      gnt,
  input  logic      busy,
  input  logic      gnt_dly,
  output bm_state_e state_q,
  output bm_state_e state_d
);
  logic bus_free;
  logic keep_mast;

  assign bus_free  = gnt && !busy;
  assign keep_mast = acc_req && gnt_dly;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (acc_req)  state_d = bus_free ? ST_MAST : ST_PEND;
        else if (gnt) state_d = ST_PARK;
      end
      ST_PARK: begin
        if (acc_req)   state_d = bus_free ? ST_MAST : ST_PEND;
        else if (!gnt) state_d = ST_IDLE;
      end
      ST_PEND: begin
        if (bus_free) state_d = ST_MAST;
      end
      ST_MAST: begin
        if (seq_end && !keep_mast) begin
          if (acc_req)  state_d = ST_PEND;
          else if (gnt) state_d = ST_PARK;
          else          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assert_stay_master_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_MAST && !seq_end) |=> state_q == ST_MAST);

  assert_dly_grant_hold_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_MAST && seq_end && acc_req && gnt_dly) |=> state_q == ST_MAST);

  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_MAST && seq_end && !(acc_req && gnt_dly)) |=> state_q != ST_MAST);

  assert_idle_stays_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_IDLE && !acc_req && !gnt) |=> state_q == ST_IDLE);
endmodule

// File: rtl/bm_hs_out.sv
module bm_hs_out
  import bm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_ns,
  input  bm_state_e state_q,
  input  bm_state_e state_d,
  output logic      br_n,
  output logic      ba_n,
  output logic      bb_n
);
  logic upd_en;
  logic br_d, ba_d, bb_d;

  assign upd_en = (state_d != state_q);

  always_comb begin
    br_d = !(state_d == ST_PEND);
    ba_d = !(state_d == ST_MAST);
    bb_d = !(state_d == ST_MAST);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      br_n <= 1'b1;
      ba_n <= 1'b1;
      bb_n <= 1'b1;
    end else if (upd_en) begin
      br_n <= br_d;
      ba_n <= ba_d;
      bb_n <= bb_d;
    end
  end

  assert_park_quiet_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_PARK) |-> (br_n && ba_n && bb_n));

  assert_req_ack_excl_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    $countones({~br_n, ~ba_n}) <= 1);
endmodule

// File: rtl/busmstr_ctrl.sv
module busmstr_ctrl
  import bm_pkg::*;
#(
  parameter int RST_STAGES = 2,
  parameter int GNT_DEPTH  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_req,
  input  logic seq_end,
  input  logic bg_n,
  input  logic bb_n_in,
  output logic br_n,
  output logic ba_n,
  output logic bb_n_out
);
  logic      rst_ns;
  logic      gnt, busy, gnt_dly;
  bm_state_e state_q, state_d;

  assign gnt  = !bg_n;
  assign busy = !bb_n_in;

  bm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  bm_gnt_dly #(.DEPTH(GNT_DEPTH)) u_dly (
    .clk(clk), .rst_ns(rst_ns), .gnt(gnt), .gnt_dly(gnt_dly)
  );

  bm_fsm u_fsm (
    .clk(clk), .rst_ns(rst_ns), .acc_req(acc_req), .seq_end(seq_end),
    .gnt(gnt), .busy(busy), .gnt_dly(gnt_dly),
    .state_q(state_q), .state_d(state_d)
  );

  bm_hs_out u_out (
    .clk(clk), .rst_ns(rst_ns), .state_q(state_q), .state_d(state_d),
    .br_n(br_n), .ba_n(ba_n), .bb_n(bb_n_out)
  );

  assert_no_cancel_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    (!br_n && !(!bg_n && bb_n_in)) |=> !br_n);

  assert_ack_needs_idle_bus_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    ($fell(ba_n) && $past(!br_n)) |-> $past(bb_n_in));

  assert_direct_no_req_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    (br_n && ba_n && acc_req && !bg_n && bb_n_in) |=> (br_n && !ba_n));
endmodule

// File: tb/busmstr_ctrl_test.sv
module busmstr_ctrl_test;
  logic clk = 1'b0;
  logic rst_n, acc_req, seq_end, bg_n, bb_n_in;
  logic br_n, ba_n, bb_n_out;

  typedef struct {
    logic [2:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int    nchk  = 0;
  int    nfail = 0;
  bit    done  = 0;

  localparam logic [2:0] O_IDLE = 3'b111;
  localparam logic [2:0] O_PEND = 3'b011;
  localparam logic [2:0] O_MAST = 3'b100;

  always #5 clk = ~clk;

  busmstr_ctrl uut (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .seq_end(seq_end),
    .bg_n(bg_n), .bb_n_in(bb_n_in),
    .br_n(br_n), .ba_n(ba_n), .bb_n_out(bb_n_out)
  );

  task automatic step(input bit req, input bit se, input bit bg, input bit bb,
                      input logic [2:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    acc_req = req; seq_end = se; bg_n = bg; bb_n_in = bb;
    it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic check_now(input logic [2:0] exp, input string tag);
    nchk++;
    if ({br_n, ba_n, bb_n_out} !== exp) begin
      nfail++;
      $display("FAIL %s: got %b expected %b", tag, {br_n, ba_n, bb_n_out}, exp);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() != 0) begin
        it = q.pop_front();
        check_now(it.exp, it.tag);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic settle();
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; acc_req = 0; seq_end = 0; bg_n = 1; bb_n_in = 1;
    repeat (3) @(negedge clk);
    check_now(O_IDLE, "R1 outputs during reset");
    rst_n = 1'b1;
    repeat (3) step(0, 0, 1, 1, O_IDLE, "R1/R11 idle after release");

    // request with no grant, then withdraw attempt, then busy blocks
    step(1, 0, 1, 1, O_PEND, "R2 idle req no grant");
    step(0, 0, 1, 1, O_PEND, "R3 req dropped stays pending");
    step(0, 1, 1, 1, O_PEND, "R3 seq_end ignored in pending");
    step(0, 0, 0, 0, O_PEND, "R4 grant but busy");
    step(0, 0, 0, 1, O_MAST, "R4 grant and free");
    step(0, 0, 1, 1, O_MAST, "R8 grant gone, no end");
    step(0, 1, 1, 1, O_IDLE, "R10 end no req no grant");
    step(0, 0, 1, 1, O_IDLE, "R11 stays idle");

    // direct entry and delayed-grant hold
    step(1, 0, 0, 1, O_MAST, "R5 req with grant direct");
    step(1, 1, 0, 1, O_MAST, "R9 end with req and grant");
    step(1, 1, 1, 1, O_MAST, "R9 grant removed same edge");
    step(1, 1, 1, 1, O_PEND, "R10 end req no delayed grant");
    step(0, 0, 0, 1, O_MAST, "R4 pending to master");
    step(0, 1, 0, 1, O_IDLE, "R10 end grant held to parked");

    // parked behaviour
    step(0, 0, 0, 1, O_IDLE, "R6 parked quiet");
    step(1, 0, 0, 1, O_MAST, "R7 parked req direct master");
    step(0, 1, 1, 1, O_IDLE, "R10 end to idle");
    step(0, 0, 0, 1, O_IDLE, "R6 idle grant to parked");
    step(0, 0, 1, 1, O_IDLE, "R7 parked loses grant");
    step(1, 0, 1, 1, O_PEND, "R7 idle again then req pends");
    step(0, 0, 0, 1, O_MAST, "R4 take bus");
    step(0, 1, 1, 1, O_IDLE, "R10 back to idle");

    // busy bus blocks direct entry
    step(1, 0, 0, 0, O_PEND, "R2 grant but busy from idle");
    step(1, 0, 0, 0, O_PEND, "R4 still busy");
    step(1, 0, 0, 1, O_MAST, "R4 busy cleared");
    step(1, 0, 1, 1, O_MAST, "R8 master holds");
    settle();

    // reset in the middle of mastership
    rst_n = 1'b0;
    #1;
    check_now(O_IDLE, "R1 reset while master");
    @(negedge clk);
    acc_req = 0; seq_end = 0; bg_n = 1; bb_n_in = 1;
    rst_n = 1'b1;
    repeat (3) step(0, 0, 1, 1, O_IDLE, "R1 idle after second reset");
    step(1, 0, 1, 1, O_PEND, "R2 works after reset");
    settle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule